// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block is the control logic that chooses the system clock from three candidates: the on-chip RC oscillator, the external crystal oscillator and the PLL. Software posts a source request. The block holds the request until the chosen source says it is ready, then commits the switch and reports the source in use on a status field. The analog oscillators, the PLL and the glitch-free multiplexer cells are outside the block. Each oscillator is seen only through a ready input, and the crystal also through a toggle input. All logic runs on one always-on reference clock.

A failure watchdog can be armed to watch the crystal's toggle input. If the toggle stops while the crystal feeds the system clock, either directly or as the PLL input, the block falls back to the RC oscillator, switches the crystal enable off and raises a sticky non-maskable interrupt flag. Software cannot switch off an oscillator that currently feeds the system clock. It cannot reconfigure the PLL while the PLL is the selected source.

Top module: `csw_top`

## Requirements
- R1: After reset the RC oscillator enable is 1 and the status field shows the RC oscillator. The crystal enable, PLL enable, PLL input select, watchdog arm and interrupt flag are all 0, and no request is pending.
- R2: Source codes are 2'b00 for the RC oscillator, 2'b01 for the crystal and 2'b10 for the PLL, and the status field uses the same codes. A request carrying 2'b11 is ignored: nothing becomes pending and the status does not change.
- R3: A request becomes pending on the edge that captures the write. It is committed on the first edge at which the target's ready input is 1, and it stays pending for as long as that input is 0.
- R4: The status field changes exactly one reference cycle after the internal selection commits. When ready rises before edge E1, the status still shows the old source after E1 and shows the new source after E1+1.
- R5: A request written while an earlier one is pending replaces it. The earlier target becoming ready then causes no switch.
- R6: A write that switches the crystal off has no effect while the crystal feeds the system clock, either directly or through the PLL (PLL input select = 1 means crystal).
- R7: A write that switches the RC oscillator off has no effect while the RC oscillator feeds the system clock, either directly or through the PLL (PLL input select = 0). The same write does take effect when another source is in use.
- R8: Writes to the PLL enable and to the PLL input select have no effect while the PLL is the selected source.
- R9: When the watchdog is armed and the crystal is in use, a failure is declared after FAIL_LIMIT reference cycles with no toggle edge. The count restarts on every edge, so a running crystal never trips it.
- R10: On a failure the selection goes to the RC oscillator, the crystal enable and the watchdog arm are cleared, the RC oscillator enable is set and the interrupt flag is set.
- R11: The interrupt flag stays 1 until the clear input is pulsed.
- R12: After a failure, writes that enable the crystal are ignored until the flag has been cleared and the watchdog re-armed. An arm write made while the flag is still set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Strobe for a source request |
| sel_req | input | 2 | Requested source code |
| iosc_wr | input | 1 | Strobe for the RC oscillator enable write |
| iosc_val | input | 1 | Value written to the RC oscillator enable |
| xosc_wr | input | 1 | Strobe for the crystal enable write |
| xosc_val | input | 1 | Value written to the crystal enable |
| pll_wr | input | 1 | Strobe for the PLL enable write |
| pll_val | input | 1 | Value written to the PLL enable |
| pllsrc_wr | input | 1 | Strobe for the PLL input select write |
| pllsrc_val | input | 1 | PLL input select (0 RC, 1 crystal) |
| mon_wr | input | 1 | Strobe for the watchdog arm write |
| mon_val | input | 1 | Value written to the watchdog arm |
| nmi_clr | input | 1 | Clears the interrupt flag |
| iosc_rdy | input | 1 | RC oscillator stable |
| xosc_rdy | input | 1 | Crystal stable |
| pll_rdy | input | 1 | PLL locked |
| xosc_tgl | input | 1 | Toggle seen from the crystal |
| iosc_en | output | 1 | RC oscillator enable |
| xosc_en | output | 1 | Crystal enable |
| pll_en | output | 1 | PLL enable |
| pll_src | output | 1 | PLL input select |
| mon_en | output | 1 | Watchdog armed |
| clk_stat | output | 2 | Source currently driving the system clock |
| sel_pending | output | 1 | A request is waiting for its source |
| nmi_flag | output | 1 | Sticky clock-failure interrupt |

## Verification
A wrong internal selection reaches clk_stat one cycle later, so a switch that commits early, late or to a replaced target shows up two edges after the ready edge. A corrupted guard appears at once as an enable output that drops when it should hold. A broken PLL freeze appears the same way, as a PLL enable or input select that changes. A miscounting watchdog shows within about FAIL_LIMIT cycles, either as a premature interrupt while the crystal toggles or as a missing fallback once it stops. A lost failure lock shows as a crystal enable that can be written before the flag is cleared and the watchdog re-armed.

// File: rtl/csw_pkg.sv
package csw_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    // selection arbiter state
    typedef struct packed {
        src_e sel;
        src_e stat;
        logic pend;
        src_e pend_src;
    } arb_t;

    // oscillator control state
    typedef struct packed {
        logic iosc_en;
        logic xosc_en;
        logic pll_en;
        logic pll_src;
        logic mon_en;
        logic nmi;
        logic lock;
    } ctl_t;

endpackage

// File: rtl/csw_xosc_watch.sv
module csw_xosc_watch #(
    parameter int LIMIT       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic tgl,
    output logic fail
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic [CNT_W-1:0]       cnt;
    } wst_t;

    wst_t q, d;
    logic edge_seen;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[SYNC_STAGES-2:0], tgl};
        d.last    = q.sync[SYNC_STAGES-1];
        edge_seen = q.sync[SYNC_STAGES-1] ^ q.last;
        fail      = 1'b0;
        if (!armed || edge_seen) begin
            d.cnt = '0;
        end else if (q.cnt == CNT_TOP) begin
            d.cnt = '0;
            fail  = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/csw_sel_arb.sv
module csw_sel_arb
    import csw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr,
    input  logic [1:0] req_src,
    input  logic [2:0] rdy,
    input  logic       force_int,
    output src_e       sel,
    output src_e       stat,
    output logic       pend
);
    arb_t q, d;
    logic tgt_rdy;

    always_comb begin
        case (q.pend_src)
            SRC_INT: tgt_rdy = rdy[0];
            SRC_EXT: tgt_rdy = rdy[1];
            SRC_PLL: tgt_rdy = rdy[2];
            default: tgt_rdy = 1'b0;
        endcase
    end

    always_comb begin
        d      = q;
        d.stat = q.sel;
        if (force_int) begin
            d.sel  = SRC_INT;
            d.pend = 1'b0;
        end else begin
            if (q.pend && tgt_rdy) begin
                d.sel  = q.pend_src;
                d.pend = 1'b0;
            end
            if (req_wr && (src_e'(req_src) != SRC_RSVD)) begin
                d.pend     = 1'b1;
                d.pend_src = src_e'(req_src);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sel      <= SRC_INT;
            q.stat     <= SRC_INT;
            q.pend     <= 1'b0;
            q.pend_src <= SRC_INT;
        end else begin
            q <= d;
        end
    end

    assign sel  = q.sel;
    assign stat = q.stat;
    assign pend = q.pend;

endmodule

// File: rtl/csw_top.sv
module csw_top
    import csw_pkg::*;
#(
    parameter int FAIL_LIMIT  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [1:0] sel_req,
    input  logic       iosc_wr,
    input  logic       iosc_val,
    input  logic       xosc_wr,
    input  logic       xosc_val,
    input  logic       pll_wr,
    input  logic       pll_val,
    input  logic       pllsrc_wr,
    input  logic       pllsrc_val,
    input  logic       mon_wr,
    input  logic       mon_val,
    input  logic       nmi_clr,
    input  logic       iosc_rdy,
    input  logic       xosc_rdy,
    input  logic       pll_rdy,
    input  logic       xosc_tgl,
    output logic       iosc_en,
    output logic       xosc_en,
    output logic       pll_en,
    output logic       pll_src,
    output logic       mon_en,
    output logic [1:0] clk_stat,
    output logic       sel_pending,
    output logic       nmi_flag
);
    localparam int NUM_SRC = 3;
    localparam int IX_INT  = 0;
    localparam int IX_EXT  = 1;

    src_e               sel_now;
    src_e               stat_now;
    logic               fail;
    logic               armed;
    logic [NUM_SRC-1:0] drives;
    logic [NUM_SRC-1:0] rdy_vec;
    ctl_t               c_q, c_d;

    assign rdy_vec = {pll_rdy, xosc_rdy, iosc_rdy};

    // which source feeds the system clock, directly or as PLL input
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_use
        if (g == NUM_SRC - 1) begin : g_pll
            assign drives[g] = (sel_now == SRC_PLL);
        end else begin : g_osc
            assign drives[g] = (sel_now == src_e'(g)) ||
                               ((sel_now == SRC_PLL) && (c_q.pll_src == 1'(g)));
        end
    end

    assign armed = c_q.mon_en && drives[IX_EXT];

    csw_xosc_watch #(
        .LIMIT      (FAIL_LIMIT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_watch (
        .clk  (clk),
        .rst_n(rst_n),
        .armed(armed),
        .tgl  (xosc_tgl),
        .fail (fail)
    );

    csw_sel_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (sel_wr),
        .req_src  (sel_req),
        .rdy      (rdy_vec),
        .force_int(fail),
        .sel      (sel_now),
        .stat     (stat_now),
        .pend     (sel_pending)
    );

    always_comb begin
        c_d = c_q;
        if (iosc_wr) begin
            if (iosc_val)               c_d.iosc_en = 1'b1;
            else if (!drives[IX_INT])   c_d.iosc_en = 1'b0;
        end
        if (xosc_wr) begin
            if (xosc_val) begin
                if (!c_q.lock)          c_d.xosc_en = 1'b1;
            end else if (!drives[IX_EXT]) begin
                c_d.xosc_en = 1'b0;
            end
        end
        if (sel_now != SRC_PLL) begin
            if (pll_wr)    c_d.pll_en  = pll_val;
            if (pllsrc_wr) c_d.pll_src = pllsrc_val;
        end
        if (mon_wr) begin
            if (!mon_val) begin
                c_d.mon_en = 1'b0;
            end else if (!c_q.nmi) begin
                c_d.mon_en = 1'b1;
                c_d.lock   = 1'b0;
            end
        end
        if (nmi_clr) c_d.nmi = 1'b0;
        if (fail) begin
            c_d.iosc_en = 1'b1;
            c_d.xosc_en = 1'b0;
            c_d.mon_en  = 1'b0;
            c_d.nmi     = 1'b1;
            c_d.lock    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.iosc_en <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign iosc_en  = c_q.iosc_en;
    assign xosc_en  = c_q.xosc_en;
    assign pll_en   = c_q.pll_en;
    assign pll_src  = c_q.pll_src;
    assign mon_en   = c_q.mon_en;
    assign nmi_flag = c_q.nmi;
    assign clk_stat = stat_now;

endmodule

// File: rtl/csw_top_chk.sv
module csw_top_chk
    import csw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input src_e       sel_now,
    input logic [1:0] clk_stat,
    input logic       xosc_rdy,
    input logic       pll_rdy,
    input logic       iosc_en,
    input logic       xosc_en,
    input logic       pll_en,
    input logic       pll_src,
    input logic       mon_en,
    input logic       nmi_flag,
    input logic       nmi_clr
);
    AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stat != 2'b11);                                                    // R2
    AST_EXT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now == SRC_EXT) && ($past(sel_now) != SRC_EXT) |-> $past(xosc_rdy)); // R3
    AST_PLL_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now == SRC_PLL) && ($past(sel_now) != SRC_PLL) |-> $past(pll_rdy));  // R3
    AST_XOSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now == SRC_EXT) && xosc_en |=> xosc_en || nmi_flag);              // R6
    AST_IOSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now == SRC_INT) && iosc_en |=> iosc_en);                          // R7
    AST_PLL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now == SRC_PLL) |=> $stable(pll_en) && $stable(pll_src));         // R8
    AST_FAIL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_flag) |-> (sel_now == SRC_INT) && !xosc_en && !mon_en);      // R10
    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_flag && !nmi_clr |=> nmi_flag);                                    // R11
    AST_XOSC_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_flag && !xosc_en |=> !xosc_en);                                    // R12
endmodule

bind csw_top csw_top_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_now (sel_now),
    .clk_stat(clk_stat),
    .xosc_rdy(xosc_rdy),
    .pll_rdy (pll_rdy),
    .iosc_en (iosc_en),
    .xosc_en (xosc_en),
    .pll_en  (pll_en),
    .pll_src (pll_src),
    .mon_en  (mon_en),
    .nmi_flag(nmi_flag),
    .nmi_clr (nmi_clr)
);

// File: tb/tb_csw_top.sv
module tb_csw_top;
    localparam int LIMIT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_wr = 0, iosc_wr = 0, iosc_val = 0, xosc_wr = 0, xosc_val = 0;
    logic pll_wr = 0, pll_val = 0, pllsrc_wr = 0, pllsrc_val = 0;
    logic mon_wr = 0, mon_val = 0, nmi_clr = 0;
    logic [1:0] sel_req = 2'b00;
    logic iosc_rdy = 1, xosc_rdy = 0, pll_rdy = 0, xosc_tgl = 0;
    logic iosc_en, xosc_en, pll_en, pll_src, mon_en, sel_pending, nmi_flag;
    logic [1:0] clk_stat;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit tgl_on = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    csw_top #(.FAIL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_req(sel_req),
        .iosc_wr(iosc_wr), .iosc_val(iosc_val), .xosc_wr(xosc_wr), .xosc_val(xosc_val),
        .pll_wr(pll_wr), .pll_val(pll_val), .pllsrc_wr(pllsrc_wr), .pllsrc_val(pllsrc_val),
        .mon_wr(mon_wr), .mon_val(mon_val), .nmi_clr(nmi_clr),
        .iosc_rdy(iosc_rdy), .xosc_rdy(xosc_rdy), .pll_rdy(pll_rdy), .xosc_tgl(xosc_tgl),
        .iosc_en(iosc_en), .xosc_en(xosc_en), .pll_en(pll_en), .pll_src(pll_src),
        .mon_en(mon_en), .clk_stat(clk_stat), .sel_pending(sel_pending), .nmi_flag(nmi_flag)
    );

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            if (tgl_on && (cyc % 4 == 0)) xosc_tgl = ~xosc_tgl;
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_sel(logic [1:0] v);
        sel_req = v; sel_wr = 1'b1; tick(1); sel_wr = 1'b0;
    endtask

    // which: 0 rc, 1 crystal, 2 pll enable, 3 pll input, 4 watchdog, 5 nmi clear
    task automatic wr_ctl(int which, logic v);
        case (which)
            0: begin iosc_wr = 1; iosc_val = v; end
            1: begin xosc_wr = 1; xosc_val = v; end
            2: begin pll_wr = 1; pll_val = v; end
            3: begin pllsrc_wr = 1; pllsrc_val = v; end
            4: begin mon_wr = 1; mon_val = v; end
            default: nmi_clr = 1;
        endcase
        tick(1);
        iosc_wr = 0; xosc_wr = 0; pll_wr = 0; pllsrc_wr = 0; mon_wr = 0; nmi_clr = 0;
    endtask

    task automatic t_reset();
        tick(3); rst_n = 1'b1; tick(1);
        chk("R1 iosc_en", iosc_en, 1);
        chk("R1 clk_stat", clk_stat, 0);
        chk("R1 xosc_en", xosc_en, 0);
        chk("R1 pll_en", pll_en, 0);
        chk("R1 pll_src", pll_src, 0);
        chk("R1 mon_en", mon_en, 0);
        chk("R1 nmi_flag", nmi_flag, 0);
        chk("R1 sel_pending", sel_pending, 0);
    endtask

    task automatic t_reserved();
        wr_sel(2'b11); tick(2);
        chk("R2 reserved pending", sel_pending, 0);
        chk("R2 reserved stat", clk_stat, 0);
    endtask

    task automatic t_rc_guard();
        wr_ctl(0, 0);
        chk("R7 rc kept while direct", iosc_en, 1);
    endtask

    task automatic t_deferred();
        wr_ctl(1, 1);
        chk("R3 crystal enabled", xosc_en, 1);
        wr_sel(2'b01);
        chk("R3 pending set", sel_pending, 1);
        tick(5);
        chk("R3 held while not ready", clk_stat, 0);
        chk("R3 still pending", sel_pending, 1);
        xosc_rdy = 1; tick(1);
        chk("R4 stat lags commit", clk_stat, 0);
        tick(1);
        chk("R4 stat after one cycle", clk_stat, 1);
        chk("R3 pending cleared", sel_pending, 0);
    endtask

    task automatic t_crystal_guard();
        wr_ctl(1, 0);
        chk("R6 crystal kept while direct", xosc_en, 1);
        wr_ctl(0, 0);
        chk("R7 rc off allowed when unused", iosc_en, 0);
        wr_ctl(0, 1);
        chk("R7 rc back on", iosc_en, 1);
    endtask

    task automatic t_replace();
        iosc_rdy = 0; pll_rdy = 0;
        wr_sel(2'b10);
        wr_sel(2'b00);
        pll_rdy = 1; tick(4);
        chk("R5 replaced target ignored", clk_stat, 1);
        chk("R5 newer still pending", sel_pending, 1);
        iosc_rdy = 1; tick(3);
        chk("R5 newer target taken", clk_stat, 0);
        pll_rdy = 0;
    endtask

    task automatic t_pll();
        wr_ctl(3, 1);
        wr_ctl(2, 1);
        chk("R8 pll input set", pll_src, 1);
        chk("R8 pll enabled", pll_en, 1);
        pll_rdy = 1;
        wr_sel(2'b10); tick(2);
        chk("R2 stat shows pll code", clk_stat, 2);
        wr_ctl(2, 0);
        chk("R8 pll enable frozen", pll_en, 1);
        wr_ctl(3, 0);
        chk("R8 pll input frozen", pll_src, 1);
        wr_ctl(1, 0);
        chk("R6 crystal kept via pll", xosc_en, 1);
        wr_ctl(0, 0);
        chk("R7 rc off allowed under crystal pll", iosc_en, 0);
        wr_ctl(0, 1);
    endtask

    task automatic t_failure();
        wr_ctl(4, 1);
        chk("R9 watchdog armed", mon_en, 1);
        tgl_on = 1; tick(100);
        chk("R9 no trip while toggling", nmi_flag, 0);
        chk("R9 pll kept while toggling", clk_stat, 2);
        tgl_on = 0; tick(8);
        chk("R9 no early trip", nmi_flag, 0);
        tick(20);
        chk("R10 nmi set", nmi_flag, 1);
        chk("R10 fallback to rc", clk_stat, 0);
        chk("R10 crystal off", xosc_en, 0);
        chk("R10 watchdog disarmed", mon_en, 0);
        chk("R10 rc on", iosc_en, 1);
    endtask

    task automatic t_recover();
        tick(10);
        chk("R11 flag sticky", nmi_flag, 1);
        wr_ctl(1, 1);
        chk("R12 crystal locked out", xosc_en, 0);
        wr_ctl(4, 1);
        chk("R12 arm refused while flagged", mon_en, 0);
        wr_ctl(5, 1);
        chk("R11 flag cleared", nmi_flag, 0);
        wr_ctl(1, 1);
        chk("R12 still locked before rearm", xosc_en, 0);
        wr_ctl(4, 1);
        chk("R12 rearmed", mon_en, 1);
        wr_ctl(1, 1);
        chk("R12 crystal enabled after rearm", xosc_en, 1);
    endtask

    initial begin
        t_reset();
        t_reserved();
        t_rc_guard();
        t_deferred();
        t_crystal_guard();
        t_replace();
        t_pll();
        t_failure();
        t_recover();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule